// File: doc/BRIEF.md
# Interleaved complementary gate sequencer for flying-capacitor arms

This block drives up to four three-level flying-capacitor arms. Two of them sit in the upper half of the converter and run in parallel. The other two sit in the lower half and are tied in series to the upper pair. A single carrier counter sets the timing for every arm. Each upper arm turns its duty word into four gate drives. The outer pair of switches and the inner pair are each driven as complementary pairs, and the inner pair runs half a carrier period behind the outer pair. The second upper arm runs the same pattern as the first, delayed by a quarter of the period. That quarter is 180 degrees divided by the two parallel arms.

The lower arms have no modulators of their own. Each lower arm copies the upper arm above it with the switch order reversed, so the lower state code is always the bitwise inverse of the upper one. The mode selects which arms drive their gates: one arm alone, the interleaved parallel pair, the complementary series pair, or all four arms in mixed operation. Mode and duty words take effect only at a carrier period boundary. A per-arm off input turns off one arm's gates without changing the timing of the other arms.

Top module: `flycap_mod_seq`

## Requirements
- R1: The carrier counts 0 to PERIOD-1 and then wraps to 0. The mode, both duty words and the shared-duty choice are sampled only on the clock edge that ends count PERIOD-1. A change made at any other time has no effect until the next period starts.
- R2: Each upper arm k drives four switches. The outer-low switch is on while its lag position, (count - k*PERIOD/4) mod PERIOD, is less than the arm's duty. The inner-low switch uses the same rule with a further PERIOD/2 of lag. The outer-high switch is the inverse of the outer-low switch, and the inner-high switch is the inverse of the inner-low switch. The two switches of a complementary pair are never on together. All outputs are registered and show the count of the previous cycle.
- R3: Upper arm 1 repeats the pattern of upper arm 0 delayed by exactly PERIOD/4 counts.
- R4: Gate layout is `gate[4j+0]` outer-high, `[4j+1]` inner-high, `[4j+2]` inner-low, `[4j+3]` outer-low. The arm index j is 0 for upper arm 0, 1 for upper arm 1, 2 for lower arm 0 and 3 for lower arm 1. Within an enabled lower arm, bits 0 to 3 carry the upper arm's bits 3, 2, 1 and 0 in that order.
- R5: `code_up` is {arm0 inner-low, arm0 outer-low, arm1 inner-low, arm1 outer-low} in bits [3:0]. It does not depend on mode or the off inputs. `code_dn` is always the bitwise inverse of `code_up`.
- R6: Mode encoding: 0 enables upper arm 0 only. 1 enables both upper arms. 2 enables upper arm 0 and lower arm 0. 3 enables all four arms. Every gate of an arm that is not enabled is 0.
- R7: When `duty_shared`=1, both upper arms use `duty_a`. Otherwise upper arm 1 uses `duty_b`.
- R8: `arm_off[j]`, with j as in R4, turns off all four gates of arm j in the next output. The other arms keep their gates unchanged, and the state codes keep their values.
- R9: With both duties equal to PERIOD/2 in mode 3, `code_up` is 0110, 0101, 1001 and 1010 over the four successive quarters of the period, starting at count 0.
- R10: With equal duties that are not a multiple of PERIOD/4, the two parallel arms never change state code in the same cycle.
- R11: While `rst` is high, all gates are 0, `code_up` is 0000, `code_dn` is 1111, the count is 0, the mode is 0 and both duties are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| mode_sel | input | 2 | arm combination, sampled at period boundary |
| duty_a | input | CW+1 | duty of upper arm 0, in counts 0..PERIOD |
| duty_b | input | CW+1 | duty of upper arm 1 when not shared |
| duty_shared | input | 1 | 1: both arms use duty_a |
| arm_off | input | 4 | per-arm gate kill |
| gate | output | 16 | registered gate drives of four arms |
| code_up | output | 4 | upper state code |
| code_dn | output | 4 | lower state code |

## Verification
The bench builds the block with PERIOD=16. The quarter-period lag is then four cycles, and every duty value from 0 to full on can be drawn. A period takes only sixteen cycles, so random mode and duty changes often arrive in the middle of a period and test the boundary latch many times. Duty 8 gives the half-duty code cycle. Duty 5 is not a multiple of the lag, so it exercises the rule that the two parallel arms never change state in the same cycle.

// File: rtl/flyseq_pkg.sv
package flyseq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_PARALLEL = 2'd1,
    MODE_SERIES   = 2'd2,
    MODE_MIXED    = 2'd3
  } seq_mode_e;

  // enabled arms, bit order {lower1, lower0, upper1, upper0}
  function automatic logic [3:0] arms_enabled(input seq_mode_e m);
    case (m)
      MODE_SINGLE:   return 4'b0001;
      MODE_PARALLEL: return 4'b0011;
      MODE_SERIES:   return 4'b0101;
      default:       return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/flyseq_carrier.sv
module flyseq_carrier
  import flyseq_pkg::*;
#(
  parameter int PERIOD = 16,
  parameter int CW     = $clog2(PERIOD),
  parameter int DW     = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_in,
  input  logic [DW-1:0] da_in,
  input  logic [DW-1:0] db_in,
  input  logic          shared_in,
  output logic [CW-1:0] cnt,
  output seq_mode_e     mode_q,
  output logic [DW-1:0] da_q,
  output logic [DW-1:0] db_q
);
  logic wrap;
  assign wrap = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mode_q <= MODE_SINGLE;
      da_q   <= '0;
      db_q   <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        mode_q <= seq_mode_e'(mode_in);
        da_q   <= da_in;
        db_q   <= shared_in ? da_in : db_in;
      end
    end
  end

  // R1: counter stays inside the period
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < PERIOD);
  // R1: settings move only when a new period starts
  a_r1_latch_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mode_q) || !$stable(da_q) || !$stable(db_q)) |-> (cnt == '0));
endmodule

// File: rtl/flyseq_arm_pwm.sv
module flyseq_arm_pwm #(
  parameter int PERIOD = 16,
  parameter int SHIFT  = 0,
  parameter int CW     = $clog2(PERIOD),
  parameter int DW     = CW + 1
) (
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] duty,
  output logic [3:0]    sw      // {outer-low, inner-low, inner-high, outer-high}
);
  localparam logic [CW:0] SH_OUT = (CW+1)'(SHIFT % PERIOD);
  localparam logic [CW:0] SH_IN  = (CW+1)'((SHIFT + PERIOD/2) % PERIOD);
  localparam logic [CW:0] PER    = (CW+1)'(PERIOD);

  function automatic logic [CW:0] lagpos(input logic [CW:0] c, input logic [CW:0] sh);
    return (c >= sh) ? c - sh : c + PER - sh;
  endfunction

  logic [CW:0] pos_out, pos_in;
  logic        on_out, on_in;

  always_comb begin
    pos_out = lagpos({1'b0, cnt}, SH_OUT);
    pos_in  = lagpos({1'b0, cnt}, SH_IN);
    on_out  = (pos_out < duty);
    on_in   = (pos_in < duty);
    sw      = {on_out, on_in, ~on_in, ~on_out};
  end
endmodule

// File: rtl/flycap_mod_seq.sv
module flycap_mod_seq
  import flyseq_pkg::*;
#(
  parameter int PERIOD = 16,
  parameter int CW     = $clog2(PERIOD),
  parameter int DW     = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic [DW-1:0] duty_a,
  input  logic [DW-1:0] duty_b,
  input  logic          duty_shared,
  input  logic [3:0]    arm_off,
  output logic [15:0]   gate,
  output logic [3:0]    code_up,
  output logic [3:0]    code_dn
);
  localparam int NPAR = 2;
  localparam int LAG  = PERIOD / (2 * NPAR);

  logic [CW-1:0] cnt;
  seq_mode_e     mode_q;
  logic [DW-1:0] dq [NPAR];
  logic [3:0]    sw [NPAR];
  logic [3:0]    en;
  logic [15:0]   gate_d;
  logic [3:0]    code_d;

  flyseq_carrier #(.PERIOD(PERIOD), .CW(CW), .DW(DW)) u_carrier (
    .clk(clk), .rst(rst), .mode_in(mode_sel), .da_in(duty_a), .db_in(duty_b),
    .shared_in(duty_shared), .cnt(cnt), .mode_q(mode_q), .da_q(dq[0]), .db_q(dq[1])
  );

  for (genvar k = 0; k < NPAR; k++) begin : g_arm
    flyseq_arm_pwm #(.PERIOD(PERIOD), .SHIFT(k * LAG), .CW(CW), .DW(DW)) u_pwm (
      .cnt(cnt), .duty(dq[k]), .sw(sw[k])
    );
    // upper arm k and its mirrored lower arm
    assign gate_d[4*k +: 4]          = en[k] ? sw[k] : 4'b0000;
    assign gate_d[4*(k+NPAR) +: 4]   = en[k+NPAR] ? {sw[k][0], sw[k][1], sw[k][2], sw[k][3]} : 4'b0000;
  end

  assign en     = arms_enabled(mode_q) & ~arm_off;
  assign code_d = {sw[0][2], sw[0][3], sw[1][2], sw[1][3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      gate    <= '0;
      code_up <= 4'b0000;
      code_dn <= 4'b1111;
    end else begin
      gate    <= gate_d;
      code_up <= code_d;
      code_dn <= ~code_d;
    end
  end

  for (genvar j = 0; j < 4; j++) begin : g_chk
    // R2: a complementary pair never conducts together
    a_r2_no_shoot: assert property (@(posedge clk) disable iff (rst)
      !(gate[4*j] && gate[4*j+3]) && !(gate[4*j+1] && gate[4*j+2]));
    // R8: an arm switched off shows no gate in the next output
    a_r8_off_dark: assert property (@(posedge clk) disable iff (rst)
      $past(arm_off[j]) |-> (gate[4*j +: 4] == 4'b0000));
  end

  logic [3:0] code_chg;
  assign code_chg = code_d ^ code_up;
  // R10: parallel arms never step together at an unaligned equal duty
  a_r10_no_joint_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && dq[0] == dq[1] && (dq[0] % DW'(LAG)) != '0)
      |-> !((|code_chg[3:2]) && (|code_chg[1:0])));
  // R5: lower code stays the inverse of the upper code
  a_r5_code_inverse: assert property (@(posedge clk) disable iff (rst)
    code_dn == ~code_up);
endmodule

// File: tb/tb_flycap_mod_seq.sv
module tb_flycap_mod_seq;
  localparam int P  = 16;
  localparam int Q  = P / 4;
  localparam int CW = $clog2(P);
  localparam int DW = CW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode_sel = 2'd0;
  logic [DW-1:0] duty_a = '0, duty_b = '0;
  logic          duty_shared = 1'b0;
  logic [3:0]    arm_off = 4'b0000;
  logic [15:0]   gate;
  logic [3:0]    code_up, code_dn;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flycap_mod_seq #(.PERIOD(P)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .duty_a(duty_a), .duty_b(duty_b),
    .duty_shared(duty_shared), .arm_off(arm_off), .gate(gate),
    .code_up(code_up), .code_dn(code_dn)
  );

  // ---- expected behaviour from the requirements ----
  function automatic bit leg(int c, int sh, int d);
    return ((c - sh + 2*P) % P) < d;
  endfunction
  function automatic logic [3:0] arm_sw(int c, int k, int d);
    bit lo, li;
    lo = leg(c, k*Q, d);
    li = leg(c, k*Q + P/2, d);
    return {lo, li, ~li, ~lo};
  endfunction
  function automatic logic [3:0] mode_arms(int m);
    case (m)
      0: return 4'b0001;
      1: return 4'b0011;
      2: return 4'b0101;
      default: return 4'b1111;
    endcase
  endfunction
  function automatic logic [15:0] f_gates(int c, int m, int d0, int d1, logic [3:0] off);
    logic [3:0] e, s0, s1;
    logic [15:0] g;
    e  = mode_arms(m) & ~off;
    s0 = arm_sw(c, 0, d0);
    s1 = arm_sw(c, 1, d1);
    g[3:0]   = e[0] ? s0 : 4'b0;
    g[7:4]   = e[1] ? s1 : 4'b0;
    g[11:8]  = e[2] ? {s0[0], s0[1], s0[2], s0[3]} : 4'b0;
    g[15:12] = e[3] ? {s1[0], s1[1], s1[2], s1[3]} : 4'b0;
    return g;
  endfunction
  function automatic logic [3:0] f_code(int c, int d0, int d1);
    logic [3:0] s0, s1;
    s0 = arm_sw(c, 0, d0);
    s1 = arm_sw(c, 1, d1);
    return {s0[2], s0[3], s1[2], s1[3]};
  endfunction

  int mc, mm, md0, md1, oc;
  logic [15:0] eg;
  logic [3:0]  eu, el;
  always @(posedge clk) begin
    if (rst) begin
      mc <= 0; mm <= 0; md0 <= 0; md1 <= 0; oc <= 0;
      eg <= '0; eu <= 4'b0000; el <= 4'b1111;
    end else begin
      mc <= (mc == P-1) ? 0 : mc + 1;
      if (mc == P-1) begin
        mm  <= int'(mode_sel);
        md0 <= int'(duty_a);
        md1 <= duty_shared ? int'(duty_a) : int'(duty_b);
      end
      eg <= f_gates(mc, mm, md0, md1, arm_off);
      eu <= f_code(mc, md0, md1);
      el <= ~f_code(mc, md0, md1);
      oc <= mc;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      chk(gate == eg, "R2 R6", "gate", int'(gate), int'(eg));
      chk(code_up == eu && code_dn == el, "R5", "codes", int'({code_up, code_dn}), int'({eu, el}));
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_cnt(int c);
    while (mc != c) tick();
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    logic [3:0] qexp [4];
    logic g3 [64];
    void'($urandom(32'd20240611));

    // R11 reset state
    repeat (4) @(negedge clk);
    chk(gate == 16'h0 && code_up == 4'h0 && code_dn == 4'hF, "R11", "reset",
        int'({gate, code_up, code_dn}), int'({16'h0, 4'h0, 4'hF}));
    rst = 1'b0;
    run(2);
    chk(gate == 16'h0001 || gate == 16'h0005 || gate == 16'h0003 || gate == 16'h000F || gate[15:4] == 0,
        "R11", "single mode after reset", int'(gate[15:4]), 0);

    // R1: mode change mid period is not taken
    mode_sel = 2'd0; duty_a = 5'd6; duty_shared = 1'b1;
    run(2*P);
    wait_cnt(3);
    mode_sel = 2'd3;
    tick();
    chk(gate[15:4] == 12'h0, "R1", "mid-period mode ignored", int'(gate[15:4]), 0);
    run(2*P);
    chk(mm == 3, "R1", "mode taken at boundary", mm, 3);

    // R9: half duty, mixed mode code sequence
    duty_a = DW'(P/2); duty_shared = 1'b1; mode_sel = 2'd3;
    run(2*P);
    qexp[0] = 4'b0110; qexp[1] = 4'b0101; qexp[2] = 4'b1001; qexp[3] = 4'b1010;
    for (int i = 0; i < P; i++) begin
      tick();
      chk(code_up == qexp[oc / Q], "R9", "half duty code", int'(code_up), int'(qexp[oc / Q]));
    end

    // R4: lower arm mirrors upper arm reversed
    chk(gate[11:8] == {gate[0], gate[1], gate[2], gate[3]}, "R4", "lower0 mirror",
        int'(gate[11:8]), int'({gate[0], gate[1], gate[2], gate[3]}));
    chk(gate[15:12] == {gate[4], gate[5], gate[6], gate[7]}, "R4", "lower1 mirror",
        int'(gate[15:12]), int'({gate[4], gate[5], gate[6], gate[7]}));

    // R3: arm 1 lags arm 0 by a quarter period
    mode_sel = 2'd1; duty_a = 5'd5;
    run(2*P);
    for (int i = 0; i < 2*P; i++) begin
      tick();
      g3[i] = gate[3];
      if (i >= Q)
        chk(gate[7] == g3[i-Q], "R3", "quarter lag", int'(gate[7]), int'(g3[i-Q]));
    end

    // R10: no joint state step at unaligned equal duty
    mode_sel = 2'd3; duty_a = 5'd5; duty_shared = 1'b1;
    run(2*P);
    prev = code_up;
    for (int i = 0; i < P; i++) begin
      tick();
      chk(!((prev[3:2] != code_up[3:2]) && (prev[1:0] != code_up[1:0])), "R10",
          "joint step", int'({prev, code_up}), 0);
      prev = code_up;
    end

    // R7: separate versus shared duty
    mode_sel = 2'd1; duty_shared = 1'b0; duty_a = DW'(P); duty_b = '0;
    run(2*P + 1);
    chk(gate[3] && !gate[7], "R7", "split duty", int'({gate[3], gate[7]}), 2);
    duty_shared = 1'b1;
    run(2*P + 1);
    chk(gate[3] && gate[7], "R7", "shared duty", int'({gate[3], gate[7]}), 3);

    // R8: disable one arm, others untouched, codes unchanged
    mode_sel = 2'd3; duty_a = 5'd7;
    run(2*P);
    arm_off = 4'b0010;
    tick();
    chk(gate[7:4] == 4'h0, "R8", "arm1 off", int'(gate[7:4]), 0);
    chk(gate[3:0] != 4'h0 && gate[15:12] != 4'h0, "R8", "others running", int'(gate), 1);
    chk(code_up == eu, "R8", "codes unaffected", int'(code_up), int'(eu));
    arm_off = 4'b0000;

    // R6: mode 2 enables upper0 and lower0 only
    mode_sel = 2'd2;
    run(2*P);
    chk(gate[7:4] == 4'h0 && gate[15:12] == 4'h0 && gate[3:0] != 4'h0, "R6", "series arms",
        int'(gate), int'(eg));

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      tick();
      if (($urandom % 8) == 0) mode_sel = 2'($urandom % 4);
      if (($urandom % 6) == 0) duty_a = DW'($urandom % (P + 1));
      if (($urandom % 6) == 0) duty_b = DW'($urandom % (P + 1));
      if (($urandom % 10) == 0) duty_shared = 1'($urandom % 2);
      if (($urandom % 12) == 0) arm_off = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0000;
      if (i == 2000) begin
        rst = 1'b1;
        @(negedge clk);
        chk(gate == 16'h0 && code_dn == 4'hF, "R11", "reset mid-run", int'(gate), 0);
        rst = 1'b0;
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule